// File: doc/BRIEF.md
# Exception State Unit

This block keeps the architectural state a processor needs when control leaves the running program for an exception handler. It holds four 32-bit registers: the faulting memory address, the status word (interrupt mask plus a three-deep stack of kernel/user and interrupt-enable pairs), the cause word (exception code plus latched interrupt requests) and the exception return address. Each cycle it looks at a synchronous exception request and at the latched hardware interrupt lines. It decides whether an exception entry happens, and if so it reports the handler address.

On entry the status stack is pushed, giving kernel mode with interrupts off. The cause code, the return address and, for address errors, the faulting address are recorded. A return-from-exception request pops the stack. Software reads the registers by index and may rewrite the status word.

Top module: `exc_state_unit`

## Requirements
- R1: After reset every register reads as zero, and no exception is reported until a request arrives.
- R2: A status write stores bits 15..8 (interrupt mask) and bits 5..0 (mode/enable stack). All other status bits read as zero.
- R3: On an exception entry, `exc_taken_o` is high in the same cycle and `handler_pc_o` equals 0x80000180 (it is zero when nothing is taken). From the next cycle, status bits 5..0 hold the previous bits 3..0 shifted up by two, with bits 1..0 cleared. The mask is unchanged.
- R4: On entry, cause bits 6..2 take the request's 5-bit code for a synchronous exception, or 0 for an interrupt. Cause bits 31..16, 9..7 and 1..0 read as zero.
- R5: On entry, the return-address register takes `exc_pc_i` minus 4.
- R6: The faulting-address register loads `fault_addr_i` only on a synchronous entry with code 4 (load/fetch address error) or 5 (store address error). Any other code leaves it unchanged.
- R7: Return-from-exception moves status bits 5..2 down into bits 3..0 and leaves bits 5..4 and the mask unchanged.
- R8: Hardware line i sets cause bit 10+i one cycle after it is high, whatever the enable bit. The bit stays set until an interrupt entry services it. An interrupt entry clears exactly the bits that were both pending and unmasked (status bit 10+i), unless the line is still high.
- R9: An interrupt is taken (`exc_is_irq_o` high) only when status bit 0 is 1 and some registered pending bit has its mask bit set, in a cycle with no synchronous request and no return request.
- R10: Priority within one cycle is: synchronous exception, then interrupt, then return-from-exception, then status write. A lower-priority action in the same cycle is dropped.
- R11: `rd_data_o` shows the faulting address for index 8, status for 12, cause for 13 and return address for 14, and zero for any other index. The read path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 5 | Code of the synchronous exception |
| exc_pc_i | input | 32 | Incremented PC of the offending instruction |
| fault_addr_i | input | 32 | Memory address of the faulting reference |
| hw_irq_i | input | 6 | Hardware interrupt request lines |
| rfe_i | input | 1 | Return-from-exception request |
| stat_wr_en_i | input | 1 | Status write strobe |
| stat_wr_data_i | input | 32 | Status write data |
| rd_idx_i | input | 5 | Register read index |
| rd_data_o | output | 32 | Register read data |
| exc_taken_o | output | 1 | Exception entry this cycle |
| exc_is_irq_o | output | 1 | The entry is an interrupt |
| handler_pc_o | output | 32 | Handler address when an entry is taken |

## Verification
Entry decisions (`exc_taken_o`, `exc_is_irq_o`, `handler_pc_o`) are combinational and due in the same cycle as the request. The bench drives stimulus after a falling edge and samples these outputs before the following rising edge. Register effects of entries, returns and writes appear on `rd_data_o` one rising edge later. An interrupt line needs one edge to become pending and can be taken only in the cycle after that. Reads are therefore queued only after the bench has advanced to the next falling edge, and interrupt checks allow for the extra latching edge.

// File: rtl/exc_state_pkg.sv
package exc_state_pkg;

  localparam logic [4:0] IDX_FAULT  = 5'd8;
  localparam logic [4:0] IDX_STATUS = 5'd12;
  localparam logic [4:0] IDX_CAUSE  = 5'd13;
  localparam logic [4:0] IDX_RET    = 5'd14;

  typedef enum logic [4:0] {
    CODE_IRQ     = 5'd0,
    CODE_ADR_LD  = 5'd4,
    CODE_ADR_ST  = 5'd5,
    CODE_BUS_I   = 5'd6,
    CODE_BUS_D   = 5'd7,
    CODE_SYSCALL = 5'd8,
    CODE_BREAK   = 5'd9,
    CODE_ILLEGAL = 5'd10,
    CODE_OVFL    = 5'd12
  } exc_code_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ENTER,
    ACT_RETURN,
    ACT_WRITE
  } stat_act_e;

  function automatic logic code_keeps_addr(input logic [4:0] code);
    return (code == CODE_ADR_LD) || (code == CODE_ADR_ST);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_state_pkg::*;
#(
  parameter int unsigned N_IRQ = 6
) (
  input  logic             sync_req_i,
  input  logic             rfe_i,
  input  logic             wr_en_i,
  input  logic             ie_cur_i,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] mask_i,
  output logic             sync_take_o,
  output logic             irq_take_o,
  output logic [N_IRQ-1:0] serviced_o,
  output stat_act_e        act_o
);

  logic [N_IRQ-1:0] live;

  always_comb begin
    live        = pend_i & mask_i;
    sync_take_o = sync_req_i;
    irq_take_o  = ie_cur_i && (|live) && !sync_req_i && !rfe_i;
    serviced_o  = irq_take_o ? live : '0;
    if (sync_take_o || irq_take_o) begin
      act_o = ACT_ENTER;
    end else if (rfe_i) begin
      act_o = ACT_RETURN;
    end else if (wr_en_i) begin
      act_o = ACT_WRITE;
    end else begin
      act_o = ACT_NONE;
    end
  end

endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_state_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  stat_act_e       act_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] status_o
);

  logic [7:0] mask_q, mask_d;
  logic [5:0] stack_q, stack_d;
  logic       upd_en;

  always_comb begin
    mask_d  = mask_q;
    stack_d = stack_q;
    upd_en  = 1'b0;
    case (act_i)
      ACT_ENTER: begin
        stack_d = {stack_q[3:0], 2'b00};
        upd_en  = 1'b1;
      end
      ACT_RETURN: begin
        stack_d = {stack_q[5:4], stack_q[5:2]};
        upd_en  = 1'b1;
      end
      ACT_WRITE: begin
        mask_d  = wr_data_i[15:8];
        stack_d = wr_data_i[5:0];
        upd_en  = 1'b1;
      end
      default: upd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else if (upd_en) begin
      mask_q  <= mask_d;
      stack_q <= stack_d;
    end
  end

  always_comb begin
    status_o       = '0;
    status_o[15:8] = mask_q;
    status_o[5:0]  = stack_q;
  end

  AST_ENTRY_KERNEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_ENTER) |=> (stack_q[1:0] == 2'b00)); // R3
  AST_ENTRY_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_ENTER) |=> (stack_q[5:2] == $past(stack_q[3:0])) && $stable(mask_q)); // R3
  AST_RETURN_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_RETURN) |=> (stack_q[3:0] == $past(stack_q[5:2])) && (stack_q[5:4] == $past(stack_q[5:4]))); // R7

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned N_IRQ = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic [4:0]       enter_code_i,
  input  logic [N_IRQ-1:0] hw_irq_i,
  input  logic [N_IRQ-1:0] serviced_i,
  output logic [N_IRQ-1:0] pend_o,
  output logic [XLEN-1:0]  cause_o
);

  localparam int unsigned PEND_LSB = 16 - N_IRQ;

  logic [4:0]       code_q, code_d;
  logic [N_IRQ-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~serviced_i) | hw_irq_i;
    code_d = enter_i ? enter_code_i : code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (enter_i) begin
      code_q <= code_d;
    end
  end

  always_comb begin
    cause_o                         = '0;
    cause_o[6:2]                    = code_q;
    cause_o[PEND_LSB +: N_IRQ]      = pend_q;
  end

  assign pend_o = pend_q;

  AST_PEND_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_irq_i) |=> ((pend_q & $past(hw_irq_i)) == $past(hw_irq_i))); // R8
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serviced_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R8

endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
  import exc_state_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     N_IRQ        = 6,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180,
  parameter int unsigned     INSN_BYTES   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_req_i,
  input  logic [4:0]       exc_code_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic [XLEN-1:0]  fault_addr_i,
  input  logic [N_IRQ-1:0] hw_irq_i,
  input  logic             rfe_i,
  input  logic             stat_wr_en_i,
  input  logic [XLEN-1:0]  stat_wr_data_i,
  input  logic [4:0]       rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             exc_taken_o,
  output logic             exc_is_irq_o,
  output logic [XLEN-1:0]  handler_pc_o
);

  localparam int unsigned PEND_LSB = 16 - N_IRQ;
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(INSN_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic [XLEN-1:0]  status_w;
  logic [XLEN-1:0]  cause_w;
  logic [N_IRQ-1:0] pend_w;
  logic [N_IRQ-1:0] serviced_w;
  logic             sync_take;
  logic             irq_take;
  logic             enter;
  logic [4:0]       enter_code;
  stat_act_e        act;

  exc_arbiter #(.N_IRQ(N_IRQ)) arb_i (
    .sync_req_i  (exc_req_i),
    .rfe_i       (rfe_i),
    .wr_en_i     (stat_wr_en_i),
    .ie_cur_i    (status_w[0]),
    .pend_i      (pend_w),
    .mask_i      (status_w[PEND_LSB +: N_IRQ]),
    .sync_take_o (sync_take),
    .irq_take_o  (irq_take),
    .serviced_o  (serviced_w),
    .act_o       (act)
  );

  exc_status_stack #(.XLEN(XLEN)) stat_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .act_i     (act),
    .wr_data_i (stat_wr_data_i),
    .status_o  (status_w)
  );

  assign enter      = sync_take || irq_take;
  assign enter_code = sync_take ? exc_code_i : CODE_IRQ;

  exc_cause_reg #(.XLEN(XLEN), .N_IRQ(N_IRQ)) cause_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .enter_i      (enter),
    .enter_code_i (enter_code),
    .hw_irq_i     (hw_irq_i),
    .serviced_i   (serviced_w),
    .pend_o       (pend_w),
    .cause_o      (cause_w)
  );

  // return address and faulting address
  logic [XLEN-1:0] ret_q, ret_d;
  logic [XLEN-1:0] fault_q, fault_d;
  logic            fault_en;

  always_comb begin
    ret_d    = exc_pc_i - PC_STEP;
    fault_en = sync_take && code_keeps_addr(exc_code_i);
    fault_d  = fault_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
    end else if (enter) begin
      ret_q <= ret_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  always_comb begin
    case (rd_idx_i)
      IDX_FAULT:  rd_data_o = fault_q;
      IDX_STATUS: rd_data_o = status_w;
      IDX_CAUSE:  rd_data_o = cause_w;
      IDX_RET:    rd_data_o = ret_q;
      default:    rd_data_o = '0;
    endcase
  end

  assign exc_taken_o  = enter;
  assign exc_is_irq_o = irq_take;
  assign handler_pc_o = enter ? HANDLER_ADDR : '0;

  AST_RET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    exc_taken_o |=> (ret_q == $past(exc_pc_i) - PC_STEP)); // R5
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(exc_taken_o && !exc_is_irq_o && code_keeps_addr(exc_code_i)) |=> $stable(fault_q)); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    exc_is_irq_o |-> (status_w[0] && (|(cause_w[PEND_LSB +: N_IRQ] & status_w[PEND_LSB +: N_IRQ])))); // R9
  AST_SYNC_BEATS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    exc_req_i |-> (exc_taken_o && !exc_is_irq_o)); // R10

endmodule

// File: tb/exc_state_unit_tb.sv
`timescale 1ns/1ps
module exc_state_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        exc_req;
  logic [4:0]  exc_code;
  logic [31:0] exc_pc;
  logic [31:0] fault_addr;
  logic [5:0]  hw_irq;
  logic        rfe;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        taken;
  logic        is_irq;
  logic [31:0] handler;

  exc_state_unit dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .exc_req_i      (exc_req),
    .exc_code_i     (exc_code),
    .exc_pc_i       (exc_pc),
    .fault_addr_i   (fault_addr),
    .hw_irq_i       (hw_irq),
    .rfe_i          (rfe),
    .stat_wr_en_i   (wr_en),
    .stat_wr_data_i (wr_data),
    .rd_idx_i       (rd_idx),
    .rd_data_o      (rd_data),
    .exc_taken_o    (taken),
    .exc_is_irq_o   (is_irq),
    .handler_pc_o   (handler)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string       req;
    int          kind;   // 0 register read, 1 taken, 2 is_irq, 3 handler
    logic [31:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      #0.05;
      begin
        sb_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = rd_data;
          1: act = {31'b0, taken};
          2: act = {31'b0, is_irq};
          default: act = handler;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d actual 0x%08h expected 0x%08h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic exp_reg(input logic [4:0] idx, input logic [31:0] e, input string req);
    sb_item_t it;
    rd_idx = idx;
    it.req = req; it.kind = 0; it.exp = e;
    sb_q.push_back(it);
    #0.2;
  endtask

  task automatic exp_flag(input int kind, input logic [31:0] e, input string req);
    sb_item_t it;
    it.req = req; it.kind = kind; it.exp = e;
    sb_q.push_back(it);
    #0.2;
  endtask

  task automatic idle();
    exc_req = 0; exc_code = 0; exc_pc = 0; fault_addr = 0;
    hw_irq = 0; rfe = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr_status(input logic [31:0] d);
    wr_en = 1; wr_data = d;
    step();
  endtask

  task automatic do_rfe();
    rfe = 1;
    step();
  endtask

  task automatic do_exc(input logic [4:0] code, input logic [31:0] pc, input logic [31:0] addr);
    exc_req = 1; exc_code = code; exc_pc = pc; fault_addr = addr;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rd_idx = 0;
    rst_n  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state, R11 unmapped index
    exp_reg(5'd8,  32'h0, "R1 fault addr after reset");
    exp_reg(5'd12, 32'h0, "R1 status after reset");
    exp_reg(5'd13, 32'h0, "R1 cause after reset");
    exp_reg(5'd14, 32'h0, "R1 ret addr after reset");
    exp_flag(1, 32'h0, "R1 no entry after reset");
    exp_reg(5'd3,  32'h0, "R11 unmapped index reads zero");

    // R2 writable fields
    wr_status(32'hFFFF_FFFF);
    exp_reg(5'd12, 32'h0000_FF3F, "R2 status write masks reserved bits");
    wr_status(32'h0000_FF01);
    exp_reg(5'd12, 32'h0000_FF01, "R2 status write value");

    // R3 R4 R5 overflow entry
    exc_req = 1; exc_code = 5'd12; exc_pc = 32'h0040_0024; fault_addr = 32'h5555_0000;
    exp_flag(1, 32'h1, "R3 entry reported");
    exp_flag(2, 32'h0, "R3 sync entry not irq");
    exp_flag(3, 32'h8000_0180, "R3 handler address");
    step();
    exp_flag(3, 32'h0, "R3 handler zero when idle");
    exp_reg(5'd12, 32'h0000_FF04, "R3 status pushed");
    exp_reg(5'd13, 32'h0000_0030, "R4 overflow code");
    exp_reg(5'd14, 32'h0040_0020, "R5 ret addr pc-4");
    exp_reg(5'd8,  32'h0, "R6 fault addr untouched by overflow");
    do_rfe();
    exp_reg(5'd12, 32'h0000_FF01, "R7 status popped");

    // R6 address errors
    do_exc(5'd4, 32'h0000_0100, 32'h1234_5679);
    exp_reg(5'd8,  32'h1234_5679, "R6 load address error captured");
    exp_reg(5'd14, 32'h0000_00FC, "R5 ret addr");
    exp_reg(5'd13, 32'h0000_0010, "R4 load addr code");
    do_rfe();
    do_exc(5'd5, 32'h0000_0204, 32'hABCD_0000);
    exp_reg(5'd8,  32'hABCD_0000, "R6 store address error captured");
    exp_reg(5'd13, 32'h0000_0014, "R4 store addr code");
    exp_reg(5'd14, 32'h0000_0200, "R5 ret addr");
    do_rfe();
    do_exc(5'd8, 32'h0000_0300, 32'hDEAD_0000);
    exp_reg(5'd8,  32'hABCD_0000, "R6 syscall keeps fault addr");
    exp_reg(5'd13, 32'h0000_0020, "R4 syscall code");
    do_rfe();

    // R3 R7 three-level stack
    wr_status(32'h0000_000D);
    exp_reg(5'd12, 32'h0000_000D, "R2 stack write");
    do_exc(5'd9, 32'h0000_0500, 32'h0);
    exp_reg(5'd12, 32'h0000_0034, "R3 first push");
    do_exc(5'd9, 32'h0000_0600, 32'h0);
    exp_reg(5'd12, 32'h0000_0010, "R3 second push");
    do_rfe();
    exp_reg(5'd12, 32'h0000_0014, "R7 first pop");
    do_rfe();
    exp_reg(5'd12, 32'h0000_0015, "R7 second pop keeps old pair");

    // R8 pending latched while disabled
    wr_status(32'h0000_FF00);
    hw_irq = 6'b000100;
    step();
    exp_reg(5'd13, 32'h0000_1024, "R8 pending latched while disabled");
    exp_flag(1, 32'h0, "R9 no entry while disabled");
    step();
    exp_reg(5'd13, 32'h0000_1024, "R8 pending sticky");

    // R9 masked
    wr_status(32'h0000_0001);
    exp_flag(1, 32'h0, "R9 no entry while masked");

    // R9 unmasked interrupt
    wr_status(32'h0000_1001);
    exc_pc = 32'h0000_2000;
    exp_flag(1, 32'h1, "R9 interrupt entry");
    exp_flag(2, 32'h1, "R9 entry is irq");
    exp_flag(3, 32'h8000_0180, "R3 handler on irq");
    step();
    exp_reg(5'd12, 32'h0000_1004, "R3 status pushed on irq");
    exp_reg(5'd13, 32'h0000_0000, "R8 serviced pending cleared, R4 irq code");
    exp_reg(5'd14, 32'h0000_1FFC, "R5 ret addr on irq");
    do_rfe();
    exp_reg(5'd12, 32'h0000_1001, "R7 pop after irq");

    // R10 sync beats pending interrupt
    hw_irq = 6'b000100;
    step();
    exp_reg(5'd13, 32'h0000_1000, "R8 pending raised again");
    exc_req = 1; exc_code = 5'd10; exc_pc = 32'h0000_3000;
    exp_flag(1, 32'h1, "R10 entry on conflict");
    exp_flag(2, 32'h0, "R10 sync wins over irq");
    step();
    exp_reg(5'd13, 32'h0000_1028, "R10 pending kept, reserved code");
    exp_reg(5'd14, 32'h0000_2FFC, "R5 ret addr");
    exp_flag(1, 32'h0, "R9 no irq in handler");
    do_rfe();
    exp_flag(1, 32'h1, "R9 irq after return");
    exp_flag(2, 32'h1, "R9 irq flag after return");

    // R10 entry beats return and write
    exc_req = 1; exc_code = 5'd9; exc_pc = 32'h0000_4000;
    rfe = 1; wr_en = 1; wr_data = 32'h0000_FFFF;
    step();
    exp_reg(5'd12, 32'h0000_1004, "R10 entry beats return and write");
    exp_reg(5'd13, 32'h0000_1024, "R10 breakpoint code");
    exp_reg(5'd14, 32'h0000_3FFC, "R5 ret addr");

    // R10 return beats write
    rfe = 1; wr_en = 1; wr_data = 32'h0000_00FF;
    step();
    exp_reg(5'd12, 32'h0000_1001, "R10 return beats write");

    wait (sb_q.size() == 0);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule